// File: doc/BRIEF.md
# Counting Semaphore Lock Bank

A bank of small counting semaphores ("locks") that pace access to shared buffers between a compute engine and a DMA engine. Each of two requester ports presents an operation against one indexed lock. An acquire names an amount N and waits until the lock holds at least N, then takes N away. A release adds N. Pairs of locks give a ping-pong handshake: the producer acquires a "space" lock and releases a "data" lock, and the consumer does the reverse.

An external agent can overwrite any lock value through a memory-mapped write port and can read any value back. This lets software preload a lock with a count, so that several acquires go through without any release in between. A release that would push a lock past its maximum is clamped there and leaves a sticky per-lock error bit.

Acknowledges are combinational. A requester holds `req` together with its operation fields until it sees `ack` high at a rising clock edge. The lock value changes at that edge.

Top module: `sema_lock_bank`

## Requirements
- R1: Out of reset each lock takes its own value from the INIT_VALS parameter. By default lock 5 starts at 1, every other lock starts at 0, and every error bit is 0.
- R2: An acquire (op = 0) of amount N on a lock is acknowledged only when `req` is high and the lock value is at least N. Otherwise `ack` stays low and the requester stalls with `req` held.
- R3: A granted acquire lowers the lock value by N, and the new value is visible after the next rising edge.
- R4: A release (op = 1) of amount N is acknowledged whenever `req` is high and nothing blocks it (R6, R7). It raises the lock value by N.
- R5: Lock values are 6-bit unsigned. A release whose sum exceeds 63 leaves the lock at 63 and sets that lock's bit in `lock_err`. The bit stays set through later operations until a register write to that lock or a reset clears it.
- R6: When both ports address the same lock in one cycle and port 0 is acknowledged, port 1 gets no ack in that cycle. Port 1 is evaluated on the following cycle against the updated value. When port 0 is not acknowledged, port 1 proceeds in that cycle.
- R7: A register write to address 0x1F000 + 0x10*k (address bits 7:4 select the lock, bits 3:0 must be zero, bits 19:8 must equal 0x1F0) loads lock k with `reg_wdata` and clears its error bit. Any port operation on that lock is not acknowledged in that cycle. Writes to any other address are ignored.
- R8: `reg_rdata` shows, combinationally, the value of the lock that `reg_raddr` decodes to under the rule of R7. It shows 0 for an address outside the window.
- R9: After a register write of 2 to a lock, two successive acquires of amount 1 are each acknowledged without any release in between, and a third one stalls.
- R10: Operations from the two ports on different locks are both acknowledged and both applied in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| p0_req | input | 1 | Port 0 request |
| p0_op | input | 1 | Port 0 operation: 0 acquire, 1 release |
| p0_idx | input | 4 | Port 0 lock index |
| p0_amt | input | 6 | Port 0 amount |
| p0_ack | output | 1 | Port 0 acknowledge (operation applied at this edge) |
| p1_req | input | 1 | Port 1 request |
| p1_op | input | 1 | Port 1 operation: 0 acquire, 1 release |
| p1_idx | input | 4 | Port 1 lock index |
| p1_amt | input | 6 | Port 1 amount |
| p1_ack | output | 1 | Port 1 acknowledge |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 20 | Register write byte address |
| reg_wdata | input | 6 | Value loaded into the addressed lock |
| reg_raddr | input | 20 | Register read byte address |
| reg_rdata | output | 6 | Value of the addressed lock, or 0 |
| lock_err | output | 16 | Sticky per-lock saturation flags |

## Verification
The bench goes after contention. It drives both ports at the same lock with a stalled acquire on port 0 and a release on port 1. A design that deferred port 1 on mere address equality would deadlock there, while one that let both through would lose one of the updates. It lands a register write on a lock that a port is hitting in the same cycle: a design with the wrong priority would apply the port's operation or overwrite it by half. It also pushes a release past 63 and follows it with more operations, which exposes wraparound and error bits that are not sticky. A long mixed phase crowds random operations onto four locks so that all these cases also meet each other, and every cycle is compared against a behavioural model.

// File: rtl/sema_pkg.sv
package sema_pkg;
  typedef enum logic {
    OP_ACQ = 1'b0,
    OP_REL = 1'b1
  } lock_op_e;

  // byte stride between lock registers is 2**SEMA_STRIDE_LSB
  localparam int SEMA_STRIDE_LSB = 4;
endpackage

// File: rtl/sema_addr_dec.sv
module sema_addr_dec import sema_pkg::*; #(
  parameter int ADDR_W = 20,
  parameter int IDX_W  = 4,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 20'h1F000
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  localparam int TOP_LSB = SEMA_STRIDE_LSB + IDX_W;

  always_comb begin
    hit = (addr[ADDR_W-1:TOP_LSB] == BASE_ADDR[ADDR_W-1:TOP_LSB]) &&
          (addr[SEMA_STRIDE_LSB-1:0] == '0);
    idx = addr[TOP_LSB-1:SEMA_STRIDE_LSB];
  end
endmodule

// File: rtl/sema_grant.sv
module sema_grant import sema_pkg::*; #(
  parameter int N_LOCKS = 16,
  parameter int VAL_W   = 6,
  parameter int AMT_W   = 6,
  parameter int IDX_W   = 4
) (
  input  logic [N_LOCKS-1:0][VAL_W-1:0] vals,
  input  logic             wr_hit,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             req0,
  input  lock_op_e         op0,
  input  logic [IDX_W-1:0] idx0,
  input  logic [AMT_W-1:0] amt0,
  input  logic             req1,
  input  lock_op_e         op1,
  input  logic [IDX_W-1:0] idx1,
  input  logic [AMT_W-1:0] amt1,
  output logic             ack0,
  output logic             ack1,
  output logic             defer1
);
  localparam int CW = ((VAL_W > AMT_W) ? VAL_W : AMT_W) + 1;

  function automatic logic can_go(lock_op_e op, logic [VAL_W-1:0] v,
                                  logic [AMT_W-1:0] a);
    return (op == OP_REL) || (CW'(v) >= CW'(a));
  endfunction

  logic blk0, blk1;

  always_comb begin
    blk0   = wr_hit && (wr_idx == idx0);
    blk1   = wr_hit && (wr_idx == idx1);
    ack0   = req0 && !blk0 && can_go(op0, vals[idx0], amt0);
    defer1 = req1 && ack0 && (idx0 == idx1);
    ack1   = req1 && !blk1 && !defer1 && can_go(op1, vals[idx1], amt1);
  end
endmodule

// File: rtl/sema_cell.sv
module sema_cell import sema_pkg::*; #(
  parameter int VAL_W = 6,
  parameter int AMT_W = 6,
  parameter logic [VAL_W-1:0] INIT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [VAL_W-1:0] wr_data,
  input  logic             sel0,
  input  lock_op_e         op0,
  input  logic [AMT_W-1:0] amt0,
  input  logic             sel1,
  input  lock_op_e         op1,
  input  logic [AMT_W-1:0] amt1,
  output logic [VAL_W-1:0] val,
  output logic             err
);
  localparam int CW = ((VAL_W > AMT_W) ? VAL_W : AMT_W) + 1;
  localparam logic [CW-1:0] MAXV = CW'((1 << VAL_W) - 1);

  typedef struct packed {
    logic             ovf;
    logic [VAL_W-1:0] sum;
  } sat_res_t;

  function automatic sat_res_t sat_add(logic [VAL_W-1:0] v, logic [AMT_W-1:0] a);
    sat_res_t r;
    logic [CW-1:0] wide;
    wide  = CW'(v) + CW'(a);
    r.ovf = (wide > MAXV);
    r.sum = r.ovf ? MAXV[VAL_W-1:0] : wide[VAL_W-1:0];
    return r;
  endfunction

  function automatic logic [VAL_W-1:0] take(logic [VAL_W-1:0] v, logic [AMT_W-1:0] a);
    return VAL_W'(CW'(v) - CW'(a));
  endfunction

  logic             sel;
  lock_op_e         op;
  logic [AMT_W-1:0] amt;
  sat_res_t         rel;

  always_comb begin
    sel = sel0 | sel1;
    op  = sel0 ? op0 : op1;
    amt = sel0 ? amt0 : amt1;
    rel = sat_add(val, amt);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val <= INIT;
      err <= 1'b0;
    end else if (wr_en) begin
      val <= wr_data;
      err <= 1'b0;
    end else if (sel) begin
      if (op == OP_ACQ) begin
        val <= take(val, amt);
      end else begin
        val <= rel.sum;
        err <= err | rel.ovf;
      end
    end
  end
endmodule

// File: rtl/sema_lock_bank.sv
module sema_lock_bank import sema_pkg::*; #(
  parameter int N_LOCKS = 16,
  parameter int VAL_W   = 6,
  parameter int AMT_W   = 6,
  parameter int ADDR_W  = 20,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 20'h1F000,
  parameter logic [N_LOCKS*VAL_W-1:0] INIT_VALS =
    {{(N_LOCKS-6){VAL_W'(0)}}, VAL_W'(1), {5{VAL_W'(0)}}},
  localparam int IDX_W = $clog2(N_LOCKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              p0_req,
  input  logic              p0_op,
  input  logic [IDX_W-1:0]  p0_idx,
  input  logic [AMT_W-1:0]  p0_amt,
  output logic              p0_ack,
  input  logic              p1_req,
  input  logic              p1_op,
  input  logic [IDX_W-1:0]  p1_idx,
  input  logic [AMT_W-1:0]  p1_amt,
  output logic              p1_ack,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_waddr,
  input  logic [VAL_W-1:0]  reg_wdata,
  input  logic [ADDR_W-1:0] reg_raddr,
  output logic [VAL_W-1:0]  reg_rdata,
  output logic [N_LOCKS-1:0] lock_err
);
  logic [N_LOCKS-1:0][VAL_W-1:0] lock_vals;
  logic             wr_in_win, wr_hit, rd_hit, p1_defer;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  lock_op_e         op0_e, op1_e;

  assign op0_e  = lock_op_e'(p0_op);
  assign op1_e  = lock_op_e'(p1_op);
  assign wr_hit = reg_we && wr_in_win;

  sema_addr_dec #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .BASE_ADDR(BASE_ADDR)) u_wdec (
    .addr(reg_waddr), .hit(wr_in_win), .idx(wr_idx)
  );

  sema_addr_dec #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .BASE_ADDR(BASE_ADDR)) u_rdec (
    .addr(reg_raddr), .hit(rd_hit), .idx(rd_idx)
  );

  assign reg_rdata = rd_hit ? lock_vals[rd_idx] : '0;

  sema_grant #(.N_LOCKS(N_LOCKS), .VAL_W(VAL_W), .AMT_W(AMT_W), .IDX_W(IDX_W)) u_grant (
    .vals(lock_vals), .wr_hit(wr_hit), .wr_idx(wr_idx),
    .req0(p0_req), .op0(op0_e), .idx0(p0_idx), .amt0(p0_amt),
    .req1(p1_req), .op1(op1_e), .idx1(p1_idx), .amt1(p1_amt),
    .ack0(p0_ack), .ack1(p1_ack), .defer1(p1_defer)
  );

  for (genvar k = 0; k < N_LOCKS; k++) begin : g_lock
    sema_cell #(
      .VAL_W(VAL_W), .AMT_W(AMT_W), .INIT(INIT_VALS[k*VAL_W +: VAL_W])
    ) u_cell (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_hit && (wr_idx == IDX_W'(k))), .wr_data(reg_wdata),
      .sel0(p0_ack && (p0_idx == IDX_W'(k))), .op0(op0_e), .amt0(p0_amt),
      .sel1(p1_ack && (p1_idx == IDX_W'(k))), .op1(op1_e), .amt1(p1_amt),
      .val(lock_vals[k]), .err(lock_err[k])
    );
  end
endmodule

// File: rtl/sema_lock_bank_chk.sv
module sema_lock_bank_chk #(
  parameter int N_LOCKS = 16,
  parameter int VAL_W   = 6,
  parameter int AMT_W   = 6,
  parameter int ADDR_W  = 20,
  localparam int IDX_W  = $clog2(N_LOCKS)
) (
  input logic clk,
  input logic rst_n,
  input logic p0_req,
  input logic p0_op,
  input logic [IDX_W-1:0] p0_idx,
  input logic [AMT_W-1:0] p0_amt,
  input logic p0_ack,
  input logic p1_req,
  input logic p1_ack,
  input logic [IDX_W-1:0] p1_idx,
  input logic wr_hit,
  input logic [IDX_W-1:0] wr_idx,
  input logic [VAL_W-1:0] reg_wdata,
  input logic [N_LOCKS-1:0][VAL_W-1:0] lock_vals,
  input logic [N_LOCKS-1:0] lock_err
);
  localparam int MAXV = (1 << VAL_W) - 1;

  p_ack_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_ack |-> p0_req) and (p1_ack |-> p1_req));

  p_acq_enough_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_ack && !p0_op) |-> (int'(lock_vals[p0_idx]) >= int'(p0_amt)));

  p_acq_sub_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_ack && !p0_op) |=>
      (int'(lock_vals[$past(p0_idx)]) ==
       $past(int'(lock_vals[p0_idx]) - int'(p0_amt))));

  p_rel_add_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_ack && p0_op && (int'(lock_vals[p0_idx]) + int'(p0_amt) <= MAXV)) |=>
      (int'(lock_vals[$past(p0_idx)]) ==
       $past(int'(lock_vals[p0_idx]) + int'(p0_amt))));

  p_saturate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_ack && p0_op && (int'(lock_vals[p0_idx]) + int'(p0_amt) > MAXV)) |=>
      ((int'(lock_vals[$past(p0_idx)]) == MAXV) && lock_err[$past(p0_idx)]));

  p_one_port_per_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_ack && p1_ack) |-> (p0_idx != p1_idx));

  p_write_blocks_ports_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |-> !((p0_ack && p0_idx == wr_idx) || (p1_ack && p1_idx == wr_idx)));

  p_write_loads_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> ((lock_vals[$past(wr_idx)] == $past(reg_wdata)) && !lock_err[$past(wr_idx)]));
endmodule

bind sema_lock_bank sema_lock_bank_chk #(
  .N_LOCKS(N_LOCKS), .VAL_W(VAL_W), .AMT_W(AMT_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .p0_req(p0_req), .p0_op(p0_op), .p0_idx(p0_idx), .p0_amt(p0_amt), .p0_ack(p0_ack),
  .p1_req(p1_req), .p1_ack(p1_ack), .p1_idx(p1_idx),
  .wr_hit(wr_hit), .wr_idx(wr_idx), .reg_wdata(reg_wdata),
  .lock_vals(lock_vals), .lock_err(lock_err)
);

// File: tb/sema_lock_bank_bench.sv
`timescale 1ns/100ps
module sema_lock_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        p0_req = 0, p0_op = 0, p1_req = 0, p1_op = 0;
  logic [3:0]  p0_idx = 0, p1_idx = 0;
  logic [5:0]  p0_amt = 0, p1_amt = 0;
  logic        p0_ack, p1_ack;
  logic        reg_we = 0;
  logic [19:0] reg_waddr = 0, reg_raddr = 20'h1F000;
  logic [5:0]  reg_wdata = 0;
  logic [5:0]  reg_rdata;
  logic [15:0] lock_err;

  int  n_checks = 0, n_fail = 0, ncyc = 0;
  int  mv[16];
  bit  me[16];
  bit  rd_auto = 1;

  always #2 clk = ~clk;

  sema_lock_bank u_sema_lock_bank (
    .clk(clk), .rst_n(rst_n),
    .p0_req(p0_req), .p0_op(p0_op), .p0_idx(p0_idx), .p0_amt(p0_amt), .p0_ack(p0_ack),
    .p1_req(p1_req), .p1_op(p1_op), .p1_idx(p1_idx), .p1_amt(p1_amt), .p1_ack(p1_ack),
    .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata), .lock_err(lock_err)
  );

  function automatic bit in_win(logic [19:0] a);
    return (a[19:8] == 12'h1F0) && (a[3:0] == 4'h0);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // one clock: compare all outputs against the model, then advance the model
  task automatic cyc();
    bit whit, e0, e1;
    int widx, ridx, s;
    logic [15:0] eerr;
    if (rd_auto) reg_raddr = 20'h1F000 + 20'((ncyc % 16) * 16);
    #0.5;
    whit = reg_we && in_win(reg_waddr);
    widx = int'(reg_waddr[7:4]);
    e0 = p0_req && !(whit && widx == int'(p0_idx)) &&
         (p0_op || mv[p0_idx] >= int'(p0_amt));
    e1 = p1_req && !(whit && widx == int'(p1_idx)) &&
         !(e0 && p0_idx == p1_idx) && (p1_op || mv[p1_idx] >= int'(p1_amt));
    check(p0_ack == e0, p0_op ? "R4 port0 ack" : "R2 port0 ack", p0_ack, e0);
    check(p1_ack == e1, (e0 && p1_req && p0_idx == p1_idx) ? "R6 port1 ack" :
          (p1_op ? "R4 port1 ack" : "R2 port1 ack"), p1_ack, e1);
    ridx = int'(reg_raddr[7:4]);
    check(int'(reg_rdata) == (in_win(reg_raddr) ? mv[ridx] : 0), "R8 rdata",
          reg_rdata, in_win(reg_raddr) ? mv[ridx] : 0);
    for (int k = 0; k < 16; k++) eerr[k] = me[k];
    check(lock_err == eerr, "R5 err flags", lock_err, eerr);
    @(posedge clk);
    if (e0) begin
      if (p0_op) begin
        s = mv[p0_idx] + p0_amt;
        if (s > 63) begin mv[p0_idx] = 63; me[p0_idx] = 1; end else mv[p0_idx] = s;
      end else mv[p0_idx] -= p0_amt;
    end
    if (e1) begin
      if (p1_op) begin
        s = mv[p1_idx] + p1_amt;
        if (s > 63) begin mv[p1_idx] = 63; me[p1_idx] = 1; end else mv[p1_idx] = s;
      end else mv[p1_idx] -= p1_amt;
    end
    if (whit) begin mv[widx] = reg_wdata; me[widx] = 0; end
    ncyc++;
    @(negedge clk);
  endtask

  task automatic peek(int k, int exp, string tag);
    reg_raddr = 20'h1F000 + 20'(k * 16);
    #0.5;
    check(int'(reg_rdata) == exp, tag, reg_rdata, exp);
    @(negedge clk);
  endtask

  task automatic expect_ack(bit a0, bit a1, string tag);
    #0.5;
    check(p0_ack == a0, tag, p0_ack, a0);
    check(p1_ack == a1, tag, p1_ack, a1);
  endtask

  task automatic idle();
    p0_req = 0; p1_req = 0; reg_we = 0;
  endtask

  task automatic wr(int k, int v);
    reg_we = 1; reg_waddr = 20'h1F000 + 20'(k * 16); reg_wdata = 6'(v);
    cyc();
    reg_we = 0;
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int k = 0; k < 16; k++) begin mv[k] = (k == 5) ? 1 : 0; me[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset values
    for (int k = 0; k < 16; k++) peek(k, (k == 5) ? 1 : 0, "R1 reset value");
    #0.5; check(lock_err == 16'h0, "R1 err reset", lock_err, 0); @(negedge clk);

    // R2: acquire stalls; port1 release proceeds since port0 is not granted
    p0_req = 1; p0_op = 0; p0_idx = 0; p0_amt = 1;
    repeat (3) cyc();
    peek(0, 0, "R2 stalled acquire leaves value");
    p1_req = 1; p1_op = 1; p1_idx = 0; p1_amt = 1;
    expect_ack(0, 1, "R6 port1 not blocked by stalled port0");
    cyc();
    p1_req = 0;
    expect_ack(1, 0, "R3 acquire after release");
    cyc();
    idle();
    peek(0, 0, "R3 acquire subtracts");

    // R9: preload 2, two acquires of 1, third stalls
    wr(2, 2);
    p0_req = 1; p0_op = 0; p0_idx = 2; p0_amt = 1;
    expect_ack(1, 0, "R9 first acquire"); cyc();
    expect_ack(1, 0, "R9 second acquire"); cyc();
    expect_ack(0, 0, "R9 third acquire stalls"); cyc();
    idle();
    peek(2, 0, "R9 value after two acquires");

    // R6: both ports release the same lock
    p0_req = 1; p0_op = 1; p0_idx = 3; p0_amt = 1;
    p1_req = 1; p1_op = 1; p1_idx = 3; p1_amt = 2;
    expect_ack(1, 0, "R6 port0 first"); cyc();
    p0_req = 0;
    expect_ack(0, 1, "R6 port1 next cycle"); cyc();
    idle();
    peek(3, 3, "R6 both releases applied");

    // R10: different locks in one cycle
    p0_req = 1; p0_op = 1; p0_idx = 7; p0_amt = 1;
    p1_req = 1; p1_op = 1; p1_idx = 8; p1_amt = 1;
    expect_ack(1, 1, "R10 both granted"); cyc();
    idle();
    peek(7, 1, "R10 lock7"); peek(8, 1, "R10 lock8");

    // R5: saturation and sticky error
    wr(4, 60);
    p0_req = 1; p0_op = 1; p0_idx = 4; p0_amt = 10;
    cyc();
    idle();
    peek(4, 63, "R5 saturated value");
    #0.5; check(lock_err[4] == 1'b1, "R5 err set", lock_err[4], 1); @(negedge clk);
    p0_req = 1; p0_op = 0; p0_idx = 4; p0_amt = 3;
    cyc();
    idle();
    #0.5; check(lock_err[4] == 1'b1, "R5 err sticky", lock_err[4], 1); @(negedge clk);
    wr(4, 0);
    #0.5; check(lock_err[4] == 1'b0, "R5 err cleared by write", lock_err[4], 0); @(negedge clk);

    // R7: write beats a same-cycle acquire; bad addresses ignored
    p0_req = 1; p0_op = 0; p0_idx = 5; p0_amt = 1;
    reg_we = 1; reg_waddr = 20'h1F050; reg_wdata = 9;
    expect_ack(0, 0, "R7 write blocks port");
    cyc();
    idle();
    peek(5, 9, "R7 write loaded");
    reg_we = 1; reg_waddr = 20'h1F054; reg_wdata = 7; cyc();
    reg_waddr = 20'h2F050; cyc();
    reg_we = 0;
    peek(5, 9, "R7 stray writes ignored");
    reg_raddr = 20'h1F0F4; #0.5;
    check(reg_rdata == 6'd0, "R8 out-of-window read", reg_rdata, 0);
    @(negedge clk);

    // mixed random traffic on four locks against the model
    for (int i = 0; i < 600; i++) begin
      p0_req = ($urandom_range(0, 3) != 0); p0_op = 1'($urandom_range(0, 1));
      p0_idx = 4'($urandom_range(0, 3));    p0_amt = 6'($urandom_range(0, 3));
      p1_req = ($urandom_range(0, 3) != 0); p1_op = 1'($urandom_range(0, 1));
      p1_idx = 4'($urandom_range(0, 3));    p1_amt = 6'($urandom_range(0, 3));
      if ($urandom_range(0, 15) == 0) p0_amt = 6'($urandom_range(30, 63));
      reg_we = ($urandom_range(0, 7) == 0);
      reg_waddr = 20'h1F000 + 20'($urandom_range(0, 3) * 16) +
                  (($urandom_range(0, 5) == 0) ? 20'h4 : 20'h0);
      reg_wdata = 6'($urandom_range(0, 63));
      cyc();
    end
    idle();
    cyc();

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule